// File: doc/BRIEF.md
# Mailbox command and status executor

This block lets a host drive a small set of logical registers through two shared bytes: a command byte and a data byte. The host writes the data byte (for a control write) and then a non-zero command byte. The executor picks up the pending command, carries it out and then clears the command byte. The cleared byte tells the host that the operation is complete, and for a status read it also tells the host that the data byte holds the result.

The command byte carries a direction flag in bit 7 and a register number in bits 6:0. Control writes set an interrupt-condition mask, a transmit retry limit and an I/O pointer. They also check the protocol identifier, strobe a pointer-reset request for the receive and transmit paths, and write through the pointer. Status reads return the protocol identifier, link counters supplied from outside, the mask, and a read through the pointer. A read through the pointer is only allowed for a fixed set of I/O addresses. Invalid requests produce a one-cycle error strobe that carries a code, and the command byte is cleared in that case as well.

Top module: `mbx_exec`

## Requirements
- R1: A non-zero command byte seen while idle is accepted on the next clock edge. The operation completes on the edge after that, so a command written at edge n reads back as zero after edge n+2, unless the host writes the command byte at edge n+2.
- R2: A control write (bit 7 = 1) copies the data byte into the addressed register and leaves the data byte unchanged. Register 12 holds the retry limit (`max_retry_o`), register 121 holds the interrupt mask (`int_mask_o`) and register 123 holds the I/O pointer. A status read of 121 returns the mask.
- R3: A status read (bit 7 = 0) writes its result into the data byte on the same edge that clears the command byte.
- R4: A control write to register 3 with a data value other than 3 raises error code 2. With a data value of 3 it raises no error. A status read of register 3 returns 3.
- R5: Control register 101 gives `clear_o` as a one-cycle pulse after completion. Control register 111 completes with no error, no pulse and no register change.
- R6: A control write to register 124 asserts `io_wr_o` during the completion cycle, with `io_addr_o` equal to the pointer and `io_wdata_o` equal to the data byte.
- R7: A status read of register 124 is allowed only when the pointer is one of 0x10–0x13, 0x20–0x23 or 0x30–0x31. When allowed, `io_rd_o` is asserted in the completion cycle and `io_rdata_i` is loaded into the data byte. Any other pointer value raises error code 1, does not assert `io_rd_o` and leaves the data byte unchanged.
- R8: Status reads of registers 6, 7, 8 and 12 return `node_addr_i`, `crc_err_cnt_i`, `rx_ovf_cnt_i` and `tx_retry_cnt_i`.
- R9: An undefined control register raises error code 1 and an undefined status register raises error code 3. The strobe `err_valid_o` lasts one cycle, and the command byte is still cleared.
- R10: If the host writes the command byte in the completion cycle, the host value is kept and is executed next. If the host writes the data byte in the completion cycle of a successful status read, the status result is kept.
- R11: After reset, the command and data bytes are 0, the mask is 0, the retry limit is 20, the pointer is 0 and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Host write strobe for the command byte |
| cmd_wdata_i | input | 8 | Host command value |
| data_wr_i | input | 1 | Host write strobe for the data byte |
| data_wdata_i | input | 8 | Host data value |
| cmd_o | output | 8 | Current command byte |
| data_o | output | 8 | Current data byte |
| node_addr_i | input | 8 | Node address for status read 6 |
| crc_err_cnt_i | input | 8 | CRC error count for status read 7 |
| rx_ovf_cnt_i | input | 8 | Receive overflow count for status read 8 |
| tx_retry_cnt_i | input | 8 | Transmit retry counter for status read 12 |
| int_mask_o | output | 8 | Interrupt-condition mask |
| max_retry_o | output | 8 | Transmit retry limit |
| clear_o | output | 1 | Pointer-reset and receive reinit pulse |
| err_valid_o | output | 1 | Error strobe |
| err_code_o | output | 2 | Error code: 1 address, 2 value, 3 range |
| io_rd_o | output | 1 | I/O window read strobe |
| io_wr_o | output | 1 | I/O window write strobe |
| io_addr_o | output | 8 | I/O window address (pointer) |
| io_wdata_o | output | 8 | I/O window write data |
| io_rdata_i | input | 8 | I/O window read data, valid in the same cycle |

## Verification
The clash that matters is a host write arriving on the very edge where the executor completes. In that cycle the clear of the command byte competes with a new host command, and the status result competes with a host data write. The bench issues a status read and drives both host strobes in its completion cycle. It then requires the new command to survive and be executed next, and the data byte to hold the status value. A behavioural model, updated on every edge from the same stimulus, judges every cycle of the run, including this one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REG_PROTO = 3;
  localparam int REG_NODE  = 6;
  localparam int REG_CRC   = 7;
  localparam int REG_OVF   = 8;
  localparam int REG_RETRY = 12;
  localparam int REG_CLEAR = 101;
  localparam int REG_NOP   = 111;
  localparam int REG_MASK  = 121;
  localparam int REG_PTR   = 123;
  localparam int REG_WIN   = 124;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ADDR  = 2'd1,
    ERR_VALUE = 2'd2,
    ERR_RANGE = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    ACT_NOP, ACT_PROTO, ACT_SET_RTY, ACT_CLEAR, ACT_SET_MASK, ACT_SET_PTR, ACT_POKE,
    ACT_RD_PROTO, ACT_RD_NODE, ACT_RD_CRC, ACT_RD_OVF, ACT_RD_RTY, ACT_RD_MASK,
    ACT_PEEK, ACT_BAD
  } act_e;

  typedef enum logic {ST_IDLE, ST_BUSY} st_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0] op_i,
  output act_e          act_o,
  output err_e          bad_o
);
  localparam int RW = CW - 1;

  logic          is_wr;
  logic [RW-1:0] rn;

  assign is_wr = op_i[CW-1];
  assign rn    = op_i[RW-1:0];

  always_comb begin
    act_o = ACT_BAD;
    bad_o = is_wr ? ERR_ADDR : ERR_RANGE;
    if (is_wr) begin
      if      (rn == RW'(REG_PROTO)) act_o = ACT_PROTO;
      else if (rn == RW'(REG_RETRY)) act_o = ACT_SET_RTY;
      else if (rn == RW'(REG_CLEAR)) act_o = ACT_CLEAR;
      else if (rn == RW'(REG_NOP))   act_o = ACT_NOP;
      else if (rn == RW'(REG_MASK))  act_o = ACT_SET_MASK;
      else if (rn == RW'(REG_PTR))   act_o = ACT_SET_PTR;
      else if (rn == RW'(REG_WIN))   act_o = ACT_POKE;
    end else begin
      if      (rn == RW'(REG_PROTO)) act_o = ACT_RD_PROTO;
      else if (rn == RW'(REG_NODE))  act_o = ACT_RD_NODE;
      else if (rn == RW'(REG_CRC))   act_o = ACT_RD_CRC;
      else if (rn == RW'(REG_OVF))   act_o = ACT_RD_OVF;
      else if (rn == RW'(REG_RETRY)) act_o = ACT_RD_RTY;
      else if (rn == RW'(REG_MASK))  act_o = ACT_RD_MASK;
      else if (rn == RW'(REG_WIN))   act_o = ACT_PEEK;
    end
  end
endmodule

// File: rtl/mbx_peek_guard.sv
module mbx_peek_guard #(
  parameter int AW       = 8,
  parameter int SER_BASE = 'h10,
  parameter int SER_N    = 4,
  parameter int TMR_BASE = 'h20,
  parameter int TMR_N    = 4,
  parameter int SW_BASE  = 'h30,
  parameter int SW_N     = 2
) (
  input  logic [AW-1:0] addr_i,
  output logic          ok_o
);
  localparam int N = SER_N + TMR_N + SW_N;

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam int SLOT = (i < SER_N) ? SER_BASE + i :
                          (i < SER_N + TMR_N) ? TMR_BASE + i - SER_N :
                          SW_BASE + i - SER_N - TMR_N;
    assign hit[i] = (addr_i == AW'(SLOT));
  end

  assign ok_o = |hit;
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs #(
  parameter int DW        = 8,
  parameter int RETRY_DEF = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_mask_i,
  input  logic          we_rty_i,
  input  logic          we_ptr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] rty_o,
  output logic [DW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      rty_o  <= DW'(RETRY_DEF);
      ptr_o  <= '0;
    end else begin
      if (we_mask_i) mask_o <= wdata_i;
      if (we_rty_i)  rty_o  <= wdata_i;
      if (we_ptr_i)  ptr_o  <= wdata_i;
    end
  end

  assert_single_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({we_mask_i, we_rty_i, we_ptr_i}) <= 1);
endmodule

// File: rtl/mbx_exec.sv
module mbx_exec
  import mbx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PROTO_ID  = 3,
  parameter int RETRY_DEF = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] data_wdata_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] data_o,
  input  logic [DW-1:0] node_addr_i,
  input  logic [DW-1:0] crc_err_cnt_i,
  input  logic [DW-1:0] rx_ovf_cnt_i,
  input  logic [DW-1:0] tx_retry_cnt_i,
  output logic [DW-1:0] int_mask_o,
  output logic [DW-1:0] max_retry_o,
  output logic          clear_o,
  output logic          err_valid_o,
  output logic [1:0]    err_code_o,
  output logic          io_rd_o,
  output logic          io_wr_o,
  output logic [DW-1:0] io_addr_o,
  output logic [DW-1:0] io_wdata_o,
  input  logic [DW-1:0] io_rdata_i
);
  st_e           st_q;
  logic [DW-1:0] cmd_q, data_q, op_q, ptr;
  act_e          act;
  err_e          bad_err, err_d;
  logic          peek_ok, fin, accept, rd_hit, err_hit;
  logic [DW-1:0] rd_val;
  logic          err_v_q, clear_q;
  err_e          err_c_q;

  mbx_decode #(.CW(DW)) u_dec (.op_i(op_q), .act_o(act), .bad_o(bad_err));

  mbx_peek_guard #(.AW(DW)) u_guard (.addr_i(ptr), .ok_o(peek_ok));

  mbx_regs #(.DW(DW), .RETRY_DEF(RETRY_DEF)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_mask_i(fin && act == ACT_SET_MASK),
    .we_rty_i (fin && act == ACT_SET_RTY),
    .we_ptr_i (fin && act == ACT_SET_PTR),
    .wdata_i  (data_q),
    .mask_o   (int_mask_o),
    .rty_o    (max_retry_o),
    .ptr_o    (ptr)
  );

  assign accept = (st_q == ST_IDLE) && (cmd_q != '0);
  assign fin    = (st_q == ST_BUSY);

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    case (act)
      ACT_RD_PROTO: begin rd_val = DW'(PROTO_ID); rd_hit = 1'b1; end
      ACT_RD_NODE:  begin rd_val = node_addr_i;   rd_hit = 1'b1; end
      ACT_RD_CRC:   begin rd_val = crc_err_cnt_i; rd_hit = 1'b1; end
      ACT_RD_OVF:   begin rd_val = rx_ovf_cnt_i;  rd_hit = 1'b1; end
      ACT_RD_RTY:   begin rd_val = tx_retry_cnt_i; rd_hit = 1'b1; end
      ACT_RD_MASK:  begin rd_val = int_mask_o;    rd_hit = 1'b1; end
      ACT_PEEK:     begin rd_val = io_rdata_i;    rd_hit = peek_ok; end
      default: ;
    endcase
  end

  always_comb begin
    err_hit = 1'b0;
    err_d   = ERR_NONE;
    case (act)
      ACT_BAD:   begin err_hit = 1'b1; err_d = bad_err; end
      ACT_PROTO: if (data_q != DW'(PROTO_ID)) begin err_hit = 1'b1; err_d = ERR_VALUE; end
      ACT_PEEK:  if (!peek_ok) begin err_hit = 1'b1; err_d = ERR_ADDR; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cmd_q   <= '0;
      data_q  <= '0;
      op_q    <= '0;
      err_v_q <= 1'b0;
      err_c_q <= ERR_NONE;
      clear_q <= 1'b0;
    end else begin
      if (accept) begin
        st_q <= ST_BUSY;
        op_q <= cmd_q;
      end else if (fin) begin
        st_q <= ST_IDLE;
      end
      // host write to COMMAND beats the completion clear
      if (cmd_wr_i)  cmd_q <= cmd_wdata_i;
      else if (fin)  cmd_q <= '0;
      // status result beats a host DATA write
      if (fin && rd_hit) data_q <= rd_val;
      else if (data_wr_i) data_q <= data_wdata_i;
      err_v_q <= fin && err_hit;
      err_c_q <= (fin && err_hit) ? err_d : ERR_NONE;
      clear_q <= fin && act == ACT_CLEAR;
    end
  end

  assign cmd_o       = cmd_q;
  assign data_o      = data_q;
  assign err_valid_o = err_v_q;
  assign err_code_o  = err_c_q;
  assign clear_o     = clear_q;
  assign io_rd_o     = fin && act == ACT_PEEK && peek_ok;
  assign io_wr_o     = fin && act == ACT_POKE;
  assign io_addr_o   = ptr;
  assign io_wdata_o  = data_q;

  assert_busy_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_BUSY |=> st_q == ST_IDLE);
  assert_done_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && !cmd_wr_i) |=> cmd_q == '0);
  assert_ctrl_keeps_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && op_q[DW-1] && !data_wr_i) |=> $stable(data_q));
  assert_value_err_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && err_code_o == ERR_VALUE) |-> op_q == DW'(8'h83));
  assert_clear_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o);
  assert_io_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_rd_o && io_wr_o));
  assert_peek_guarded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_o |-> peek_ok);
  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |=> !err_valid_o);
  assert_err_coded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> err_code_o != ERR_NONE);
endmodule

// File: tb/tb_mbx_exec.sv
`timescale 1ns/1ps
module tb_mbx_exec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, data_wr = 1'b0;
  logic [7:0] cmd_wd = '0, data_wd = '0;
  logic [7:0] cmd_o, data_o, mask_o, rty_o, io_addr, io_wdata, io_rdata;
  logic clear_o, err_v, io_rd, io_wr;
  logic [1:0] err_c;
  logic [7:0] node = 8'h2C, crc = 8'h11, ovf = 8'h07, trc = 8'h03;
  int checks = 0, fails = 0;
  int poke_n = 0;
  logic [7:0] poke_a, poke_d;

  always #5 clk = ~clk;
  assign io_rdata = io_addr ^ 8'hA5;

  mbx_exec dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wd),
    .data_wr_i(data_wr), .data_wdata_i(data_wd), .cmd_o(cmd_o), .data_o(data_o),
    .node_addr_i(node), .crc_err_cnt_i(crc), .rx_ovf_cnt_i(ovf), .tx_retry_cnt_i(trc),
    .int_mask_o(mask_o), .max_retry_o(rty_o), .clear_o(clear_o),
    .err_valid_o(err_v), .err_code_o(err_c), .io_rd_o(io_rd), .io_wr_o(io_wr),
    .io_addr_o(io_addr), .io_wdata_o(io_wdata), .io_rdata_i(io_rdata));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit in_win(int a);
    return (a >= 'h10 && a <= 'h13) || (a >= 'h20 && a <= 'h23) || (a >= 'h30 && a <= 'h31);
  endfunction

  // behavioural reference model
  int m_busy, m_cmd, m_data, m_op, m_mask, m_rty, m_ptr, m_ev, m_ec, m_clr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cmd = 0; m_data = 0; m_op = 0; m_mask = 0; m_rty = 20; m_ptr = 0;
      m_ev = 0; m_ec = 0; m_clr = 0;
    end else begin
      int nc, nd, r;
      bit rd;
      nc = m_cmd; nd = m_data; rd = 0; m_ev = 0; m_ec = 0; m_clr = 0;
      if (m_busy) begin
        r = m_op & 127;
        nc = 0;
        if (m_op & 128) begin
          case (r)
            3:   if (m_data != 3) begin m_ev = 1; m_ec = 2; end
            12:  m_rty = m_data;
            101: m_clr = 1;
            111, 124: ;
            121: m_mask = m_data;
            123: m_ptr = m_data;
            default: begin m_ev = 1; m_ec = 1; end
          endcase
        end else begin
          rd = 1;
          case (r)
            3: nd = 3;
            6: nd = node;
            7: nd = crc;
            8: nd = ovf;
            12: nd = trc;
            121: nd = m_mask;
            124: if (in_win(m_ptr)) nd = m_ptr ^ 'hA5;
                 else begin rd = 0; m_ev = 1; m_ec = 1; end
            default: begin rd = 0; m_ev = 1; m_ec = 3; end
          endcase
        end
        m_busy = 0;
      end else if (m_cmd != 0) begin
        m_op = m_cmd; m_busy = 1;
      end
      if (cmd_wr) nc = cmd_wd;
      if (data_wr && !rd) nd = data_wd;
      m_cmd = nc; m_data = nd;
    end
  end

  always @(posedge clk) if (io_wr) begin poke_n++; poke_a = io_addr; poke_d = io_wdata; end

  // compare on every cycle
  always @(negedge clk) if (rst_n) begin
    bit ewr, erd;
    ewr = m_busy != 0 && m_op == 'hFC;
    erd = m_busy != 0 && m_op == 'h7C && in_win(m_ptr);
    chk("R1 cmd", cmd_o, m_cmd);
    chk("R3 data", data_o, m_data);
    chk("R9 err_valid", err_v, m_ev);
    chk("R9 err_code", err_c, m_ec);
    chk("R5 clear", clear_o, m_clr);
    chk("R2 mask", mask_o, m_mask);
    chk("R2 retry", rty_o, m_rty);
    chk("R6 io_wr", io_wr, ewr);
    chk("R7 io_rd", io_rd, erd);
    if (ewr || erd) chk("R6 io_addr", io_addr, m_ptr);
    if (ewr) chk("R6 io_wdata", io_wdata, m_data);
  end

  task automatic issue(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    cmd_wr = 1; cmd_wd = c; data_wr = 1; data_wd = d;
    @(negedge clk);
    cmd_wr = 0; data_wr = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cmd", cmd_o, 0); chk("R11 data", data_o, 0);
    chk("R11 mask", mask_o, 0); chk("R11 retry", rty_o, 20);
    chk("R11 strobes", {err_v, clear_o, io_rd, io_wr}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 timing: pending after accept, cleared after completion
    @(negedge clk); cmd_wr = 1; cmd_wd = 8'h06;
    @(negedge clk); cmd_wr = 0;
    @(negedge clk); chk("R1 still pending", cmd_o, 8'h06);
    @(negedge clk); chk("R1 cleared", cmd_o, 0); chk("R8 node", data_o, node);

    issue(8'h03, 8'h00); chk("R4 read id", data_o, 3); chk("R3 cmd zero", cmd_o, 0);
    issue(8'h83, 8'h03); chk("R4 good id no err", err_v, 0);
    issue(8'h83, 8'h05); chk("R4 bad id err", err_v, 1); chk("R4 code", err_c, 2);
    @(negedge clk); chk("R9 one-cycle strobe", err_v, 0);

    issue(8'hF9, 8'h5A); chk("R2 mask", mask_o, 8'h5A); chk("R2 data kept", data_o, 8'h5A);
    issue(8'h79, 8'h00); chk("R2 mask read", data_o, 8'h5A);
    issue(8'h8C, 8'h07); chk("R2 retry", rty_o, 8'h07);
    issue(8'h07, 8'h00); chk("R8 crc", data_o, crc);
    issue(8'h08, 8'h00); chk("R8 ovf", data_o, ovf);
    issue(8'h0C, 8'h00); chk("R8 retry cnt", data_o, trc);

    issue(8'hFB, 8'h21); issue(8'h7C, 8'h00);
    chk("R7 peek ok", data_o, 8'h21 ^ 8'hA5); chk("R7 no err", err_v, 0);
    issue(8'hFB, 8'h31); issue(8'h7C, 8'h00); chk("R7 peek switch", data_o, 8'h31 ^ 8'hA5);
    issue(8'hFB, 8'h44); issue(8'h7C, 8'h66);
    chk("R7 blocked err", err_v, 1); chk("R7 code", err_c, 1); chk("R7 data kept", data_o, 8'h66);
    issue(8'hFB, 8'h14); issue(8'h7C, 8'h00); chk("R7 edge blocked", err_c, 1);

    issue(8'hFC, 8'h99);
    chk("R6 poke count", poke_n, 1); chk("R6 poke addr", poke_a, 8'h14); chk("R6 poke data", poke_d, 8'h99);

    issue(8'hE5, 8'h00); chk("R5 clear pulse", clear_o, 1);
    @(negedge clk); chk("R5 clear drops", clear_o, 0);
    issue(8'hEF, 8'h12); chk("R5 nop no err", err_v, 0); chk("R5 nop no clear", clear_o, 0);
    chk("R5 nop mask kept", mask_o, 8'h5A);

    issue(8'h80, 8'h00); chk("R9 ctl undefined", err_c, 1); chk("R9 cmd cleared", cmd_o, 0);
    issue(8'h32, 8'h00); chk("R9 sts undefined", err_c, 3);
    issue(8'h7B, 8'h00); chk("R9 sts 123 undefined", err_c, 3);

    // R10: host writes both bytes in the completion cycle of a status read
    @(negedge clk); cmd_wr = 1; cmd_wd = 8'h06;
    @(negedge clk); cmd_wr = 0;
    @(negedge clk); cmd_wr = 1; cmd_wd = 8'h07; data_wr = 1; data_wd = 8'h55;
    @(negedge clk); cmd_wr = 0; data_wr = 0;
    chk("R10 host cmd kept", cmd_o, 8'h07); chk("R10 status data kept", data_o, node);
    @(negedge clk); @(negedge clk);
    chk("R10 next executed", data_o, crc); chk("R10 cmd cleared", cmd_o, 0);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] c;
      c = 8'((i * 37 + 3) ^ (i << 5));
      if (c == 0) c = 8'h03;
      issue(c, 8'(i * 13 + 16));
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule